// File: doc/BRIEF.md
# Streaming 3x3 Image Convolver

This block applies a 3x3 kernel to a raster-scanned image of fixed row length as the pixels arrive. Pixels enter one per clock through a valid/ready stream. Each accepted pixel is pushed into a single flat shift chain. Nine fixed taps on that chain always present the current 3x3 neighbourhood. Nine multiplies and an adder tree then reduce the window to one signed result. No line memory with many read ports is needed, because each cycle writes only one new pixel into storage.

Results leave through a second valid/ready stream. Each result carries a flag that marks whether its window centre lies inside the image. Windows whose centre sits on the first row, the first column or the last column are still emitted, but with the flag low, and their data has no meaning. A frame-start input, given together with an accepted pixel, marks that pixel as the top-left corner of a new image and restarts the warm-up. The nine signed kernel weights are loaded through a small write-only register port.

Top module: `conv3x3_stream`

## Requirements
- R1: For an output with the interior flag high, whose window centre is pixel (r,c), out_data equals the sum over dy,dx in {-1,0,+1} of pixel(r+dy,c+dx) times the weight at address (dy+1)*3+(dx+1). Address 0 is the upper-left weight and address 8 is the lower-right weight. Pixels are 8-bit unsigned, weights are 8-bit two's complement, and out_data is a 20-bit two's complement value.
- R2: Every output belongs to one accepted pixel and leaves in acceptance order. The output tied to the pixel at row r, column c of the frame (0-based, raster order) has its window centred on (r-1,c-1).
- R3: After reset or a frame start, the first 2W+2 accepted pixels (W = IMG_W) produce no output. Every later accepted pixel of the frame produces exactly one output.
- R4: out_interior is high exactly when the producing pixel has row >= 2 and column >= 2, which means the window centre is off the first row, the first column and the last column. out_interior is never high while out_valid is low.
- R5: With no stall, a pixel accepted at clock edge k makes its output valid right after edge k+3.
- R6: While out_ready stays high, in_ready stays high and one pixel is accepted on every cycle that in_valid is high.
- R7: When out_valid is high and out_ready is low, in_ready is low. In the next cycle out_valid, out_data and out_interior are unchanged, and no pixel is lost.
- R8: Cycles without an accepted pixel leave the window storage unchanged, so gaps in in_valid do not change any result.
- R9: A cycle with cfg_we high writes cfg_data into the weight at cfg_addr for addresses 0 to 8. Writes to addresses 9 to 15 change nothing. Reset sets all weights to zero.
- R10: frame_start high together with an accepted pixel makes that pixel row 0, column 0 and restarts the R3 warm-up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Marks the accompanying pixel as the first of a frame |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block can take a pixel this cycle |
| in_pix | input | 8 | Unsigned input pixel |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_data | output | 20 | Signed filtered value |
| out_interior | output | 1 | Window centre lies inside the image |
| cfg_we | input | 1 | Weight write strobe |
| cfg_addr | input | 4 | Weight address, 0 to 8 valid |
| cfg_data | input | 8 | Signed weight value |

## Verification
Assertions check these properties on every cycle: the output registers hold under backpressure; the shift chain moves only on an accepted pixel and loads that pixel; the column counter wraps at the row end; a frame start resets the fill count; the interior flag implies valid; ignored weight addresses leave the bank untouched; and the three-edge latency holds whenever the pipeline advances. The arithmetic, the warm-up count, the mapping of weight addresses to window positions and the placement of the flag across a whole frame are only visible in the bench. The bench compares every output against a reference computed from the stored frame, with random gaps and stalls, extreme weights and pixels, and frames that restart partway.

// File: rtl/conv3x3_pkg.sv
package conv3x3_pkg;

  localparam int NTAP = 9;

  // Chain stage holding kernel position k (k = row*3 + col, row 0 = top).
  // Stage 0 holds the newest pixel, which is the lower-right corner.
  function automatic int tap_stage(input int k, input int row_len);
    int ky;
    int kx;
    ky = k / 3;
    kx = k % 3;
    return (2 - ky) * row_len + (2 - kx);
  endfunction

endpackage

// File: rtl/c3_window_chain.sv
module c3_window_chain
  import conv3x3_pkg::*;
#(
  parameter int IMG_W = 8,
  parameter int PIX_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    shift_i,
  input  logic [PIX_W-1:0]        pix_i,
  output logic [NTAP*PIX_W-1:0]   taps_o
);

  localparam int DEPTH = 2 * IMG_W + 3;

  logic [PIX_W-1:0] sr [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) sr[i] <= '0;
    end else if (shift_i) begin
      sr[0] <= pix_i;
      for (int i = 1; i < DEPTH; i++) sr[i] <= sr[i-1];
    end
  end

  for (genvar k = 0; k < NTAP; k++) begin : g_tap
    assign taps_o[k*PIX_W +: PIX_W] = sr[tap_stage(k, IMG_W)];
  end

  // R8
  shift_load_chk: assert property (@(posedge clk) disable iff (rst)
    shift_i |=> (sr[0] == $past(pix_i)) && (sr[1] == $past(sr[0])));

  // R8
  chain_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_i |=> $stable(sr[0]) && $stable(sr[DEPTH-1]));

endmodule

// File: rtl/c3_coef_bank.sv
module c3_coef_bank
  import conv3x3_pkg::*;
#(
  parameter int COEF_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [COEF_W-1:0]       data_i,
  output logic [NTAP*COEF_W-1:0]  coefs_o
);

  logic [COEF_W-1:0] coef_q [NTAP];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NTAP; i++) coef_q[i] <= '0;
    end else if (we_i) begin
      for (int i = 0; i < NTAP; i++) begin
        if (addr_i == ADDR_W'(i)) coef_q[i] <= data_i;
      end
    end
  end

  for (genvar k = 0; k < NTAP; k++) begin : g_flat
    assign coefs_o[k*COEF_W +: COEF_W] = coef_q[k];
  end

  // R9
  coef_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (we_i && (addr_i >= ADDR_W'(NTAP))) |=> $stable(coefs_o));

endmodule

// File: rtl/c3_raster_tracker.sv
module c3_raster_tracker #(
  parameter int IMG_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic acc_i,
  input  logic sof_i,
  output logic emit_o,
  output logic interior_o
);

  localparam int CW       = $clog2(IMG_W);
  localparam int FILL_MAX = 2 * IMG_W + 2;
  localparam int FW       = $clog2(FILL_MAX + 1);

  logic [CW-1:0] col_q, cur_col;
  logic [1:0]    row_q, cur_row;
  logic [FW-1:0] fill_q, cur_fill;
  logic          wrap;

  always_comb begin
    cur_col  = sof_i ? '0 : col_q;
    cur_row  = sof_i ? '0 : row_q;
    cur_fill = sof_i ? '0 : fill_q;
    wrap     = (cur_col == CW'(IMG_W - 1));
  end

  assign emit_o     = (cur_fill == FW'(FILL_MAX));
  assign interior_o = (cur_row == 2'd2) && (cur_col >= CW'(2));

  always_ff @(posedge clk) begin
    if (rst) begin
      col_q  <= '0;
      row_q  <= '0;
      fill_q <= '0;
    end else if (acc_i) begin
      col_q  <= wrap ? '0 : cur_col + 1'b1;
      if (wrap && cur_row != 2'd2) row_q <= cur_row + 1'b1;
      else                         row_q <= cur_row;
      fill_q <= emit_o ? cur_fill : cur_fill + 1'b1;
    end
  end

  // R10
  sof_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_i && sof_i) |=> (fill_q == FW'(1)) && (col_q == CW'(1)) && (row_q == 2'd0));

  // R2
  col_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_i && !sof_i && col_q == CW'(IMG_W - 1)) |=> (col_q == '0));

endmodule

// File: rtl/c3_mac_pipe.sv
module c3_mac_pipe
  import conv3x3_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 8,
  parameter int ACC_W  = 20
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en_i,
  input  logic                    v_i,
  input  logic                    f_i,
  input  logic [NTAP*PIX_W-1:0]   taps_i,
  input  logic [NTAP*COEF_W-1:0]  coefs_i,
  output logic                    v_o,
  output logic                    f_o,
  output logic [ACC_W-1:0]        sum_o
);

  localparam int PROD_W = PIX_W + COEF_W + 1;
  localparam int NROW   = 3;

  logic signed [PROD_W-1:0] prod_d [NTAP];
  logic signed [PROD_W-1:0] prod_q [NTAP];
  logic signed [ACC_W-1:0]  rs_q   [NROW];
  logic signed [ACC_W-1:0]  sum_q;
  logic                     va_q, fa_q, vb_q, fb_q, vc_q, fc_q;

  for (genvar k = 0; k < NTAP; k++) begin : g_mul
    logic signed [PROD_W-1:0] px_e;
    logic signed [PROD_W-1:0] cf_e;
    assign px_e      = PROD_W'($signed({1'b0, taps_i[k*PIX_W +: PIX_W]}));
    assign cf_e      = PROD_W'($signed(coefs_i[k*COEF_W +: COEF_W]));
    assign prod_d[k] = px_e * cf_e;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NTAP; k++) prod_q[k] <= '0;
      for (int j = 0; j < NROW; j++) rs_q[j] <= '0;
      sum_q <= '0;
      va_q  <= 1'b0;
      fa_q  <= 1'b0;
      vb_q  <= 1'b0;
      fb_q  <= 1'b0;
      vc_q  <= 1'b0;
      fc_q  <= 1'b0;
    end else if (en_i) begin
      for (int k = 0; k < NTAP; k++) prod_q[k] <= prod_d[k];
      for (int j = 0; j < NROW; j++) begin
        rs_q[j] <= ACC_W'(prod_q[3*j]) + ACC_W'(prod_q[3*j+1]) + ACC_W'(prod_q[3*j+2]);
      end
      sum_q <= rs_q[0] + rs_q[1] + rs_q[2];
      va_q  <= v_i;
      fa_q  <= f_i;
      vb_q  <= va_q;
      fb_q  <= fa_q;
      vc_q  <= vb_q;
      fc_q  <= fb_q;
    end
  end

  assign v_o   = vc_q;
  assign f_o   = fc_q;
  assign sum_o = sum_q;

endmodule

// File: rtl/conv3x3_stream.sv
module conv3x3_stream
  import conv3x3_pkg::*;
#(
  parameter int IMG_W  = 8,
  parameter int PIX_W  = 8,
  parameter int COEF_W = 8,
  parameter int ACC_W  = 20,
  parameter int CFG_AW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PIX_W-1:0]  in_pix,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ACC_W-1:0]  out_data,
  output logic              out_interior,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [COEF_W-1:0] cfg_data
);

  logic                   adv;
  logic                   acc;
  logic                   emit;
  logic                   interior;
  logic                   v0_q, f0_q;
  logic [NTAP*PIX_W-1:0]  taps;
  logic [NTAP*COEF_W-1:0] coefs;

  // The whole pipeline advances together unless a result is waiting.
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;
  assign acc      = in_valid && adv;

  c3_raster_tracker #(.IMG_W(IMG_W)) u_track (
    .clk        (clk),
    .rst        (rst),
    .acc_i      (acc),
    .sof_i      (frame_start),
    .emit_o     (emit),
    .interior_o (interior)
  );

  c3_window_chain #(.IMG_W(IMG_W), .PIX_W(PIX_W)) u_chain (
    .clk     (clk),
    .rst     (rst),
    .shift_i (acc),
    .pix_i   (in_pix),
    .taps_o  (taps)
  );

  c3_coef_bank #(.COEF_W(COEF_W), .ADDR_W(CFG_AW)) u_coef (
    .clk     (clk),
    .rst     (rst),
    .we_i    (cfg_we),
    .addr_i  (cfg_addr),
    .data_i  (cfg_data),
    .coefs_o (coefs)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      v0_q <= 1'b0;
      f0_q <= 1'b0;
    end else if (adv) begin
      v0_q <= acc && emit;
      f0_q <= acc && emit && interior;
    end
  end

  c3_mac_pipe #(.PIX_W(PIX_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_mac (
    .clk     (clk),
    .rst     (rst),
    .en_i    (adv),
    .v_i     (v0_q),
    .f_i     (f0_q),
    .taps_i  (taps),
    .coefs_i (coefs),
    .v_o     (out_valid),
    .f_o     (out_interior),
    .sum_o   (out_data)
  );

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data) && $stable(out_interior));

  // R7
  stall_block_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  // R4
  interior_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_interior |-> out_valid);

  // R5
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(acc && emit, 3) && $past(adv, 2) && $past(adv, 1) && adv) |=> out_valid);

endmodule

// File: tb/conv3x3_stream_bench.sv
module conv3x3_stream_bench;

  localparam int W      = 8;
  localparam int H      = 6;
  localparam int FR_MAX = 64;
  localparam int WARM   = 2 * W + 2;

  logic        clk = 1'b0;
  logic        rst;
  logic        frame_start;
  logic        in_valid;
  logic        in_ready;
  logic [7:0]  in_pix;
  logic        out_valid;
  logic        out_ready;
  logic [19:0] out_data;
  logic        out_interior;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [7:0]  cfg_data;

  always #4 clk = ~clk;

  conv3x3_stream #(.IMG_W(W)) u_conv3x3_stream (
    .clk          (clk),
    .rst          (rst),
    .frame_start  (frame_start),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_pix       (in_pix),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_data     (out_data),
    .out_interior (out_interior),
    .cfg_we       (cfg_we),
    .cfg_addr     (cfg_addr),
    .cfg_data     (cfg_data)
  );

  int nchk = 0;
  int nbad = 0;
  bit done = 1'b0;

  int fr [FR_MAX];
  int kc [9];
  int exp_val [$];
  bit exp_int [$];
  int idx;
  int stepn = 0;
  int acc_step;
  int first_seen;
  int busy_steps;
  bit stall_prev = 1'b0;
  logic [19:0] hold_data;
  bit hold_int;

  function automatic int window_sum(input int n);
    int r;
    int c;
    int s;
    r = n / W;
    c = n % W;
    s = 0;
    for (int ky = 0; ky < 3; ky++)
      for (int kx = 0; kx < 3; kx++)
        s += fr[(r - 2 + ky) * W + (c - 2 + kx)] * kc[ky*3 + kx];
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic model_push(input int n);
    int r;
    int c;
    bit intr;
    r = n / W;
    c = n % W;
    if (n >= WARM) begin
      intr = (r >= 2) && (c >= 2);
      exp_int.push_back(intr);
      exp_val.push_back(intr ? window_sum(n) : 0);
    end
  endtask

  task automatic step_once(input int pv, input int pr, input int npix);
    int ev;
    bit ei;
    @(negedge clk);
    stepn++;
    if (stall_prev) begin
      check(out_valid && out_data == hold_data && out_interior == hold_int,
            "R7 hold", int'($signed(out_data)), int'($signed(hold_data)));
    end
    in_valid    = (idx < npix) && (($urandom % 100) < pv);
    frame_start = (idx == 0);
    in_pix      = (idx < npix) ? 8'(fr[idx]) : 8'd0;
    out_ready   = (($urandom % 100) < pr);
    #1;
    if (out_valid && first_seen < 0) first_seen = stepn;
    if (!in_ready) busy_steps++;
    if (out_valid && !out_ready) check(!in_ready, "R7 in_ready", int'(in_ready), 0);
    if (in_valid && in_ready) begin
      model_push(idx);
      if (idx == WARM && acc_step < 0) acc_step = stepn;
      idx++;
    end
    if (out_valid && out_ready) begin
      if (exp_val.size() == 0) begin
        check(1'b0, "R3 unexpected output", 1, 0);
      end else begin
        ev = exp_val.pop_front();
        ei = exp_int.pop_front();
        check(out_interior == ei, "R4 interior flag", int'(out_interior), int'(ei));
        if (ei) check($signed(out_data) == ev, "R1 R2 value", int'($signed(out_data)), ev);
      end
    end
    stall_prev = out_valid && !out_ready;
    hold_data  = out_data;
    hold_int   = out_interior;
  endtask

  task automatic run_frame(input int npix, input int pv, input int pr);
    idx = 0;
    while (idx < npix) step_once(pv, pr, npix);
  endtask

  task automatic drain();
    repeat (12) step_once(0, 100, 0);
    check(exp_val.size() == 0, "R3 output count", exp_val.size(), 0);
  endtask

  task automatic write_coef(input int a, input int v);
    @(negedge clk);
    cfg_we   = 1'b1;
    cfg_addr = 4'(a);
    cfg_data = 8'(v);
    @(negedge clk);
    cfg_we   = 1'b0;
  endtask

  task automatic load_kernel();
    for (int i = 0; i < 9; i++) write_coef(i, kc[i]);
  endtask

  task automatic fill_random();
    for (int i = 0; i < FR_MAX; i++) fr[i] = $urandom % 256;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; frame_start = 0; in_valid = 0; in_pix = 0; out_ready = 0;
    cfg_we = 0; cfg_addr = 0; cfg_data = 0;
    idx = 0; acc_step = -1; first_seen = -1; busy_steps = 0;
    for (int i = 0; i < 9; i++) kc[i] = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    check(!out_valid && out_data == '0 && !out_interior, "reset outputs", int'(out_valid), 0);
    check(in_ready, "R6 ready after reset", int'(in_ready), 1);

    // Zero weights after reset, full rate: R9 reset value, R5 latency, R6 rate
    fill_random();
    run_frame(W*H, 100, 100);
    drain();
    check(first_seen - acc_step == 4, "R5 latency", first_seen - acc_step, 4);
    check(busy_steps == 0, "R6 full rate", busy_steps, 0);

    // Random weights with junk writes to unused addresses (R9), gaps (R8), stalls (R7)
    for (int i = 0; i < 9; i++) kc[i] = $signed(8'($urandom));
    load_kernel();
    for (int a = 9; a < 16; a++) write_coef(a, 8'h7f);
    fill_random();
    run_frame(W*H, 60, 50);
    drain();

    // Directed: one-hot weights place each window position (R1 R2)
    for (int p = 0; p < 9; p++) begin
      for (int i = 0; i < 9; i++) kc[i] = (i == p) ? 1 : 0;
      load_kernel();
      for (int i = 0; i < FR_MAX; i++) fr[i] = i;
      run_frame(W*H, 100, 100);
      drain();
    end

    // Extremes: largest positive and most negative sums (R1)
    for (int i = 0; i < FR_MAX; i++) fr[i] = 255;
    for (int i = 0; i < 9; i++) kc[i] = 127;
    load_kernel();
    run_frame(W*H, 100, 70);
    drain();
    for (int i = 0; i < 9; i++) kc[i] = -128;
    load_kernel();
    run_frame(W*H, 80, 100);
    drain();

    // Frame restart partway (R10 R3): short, then longer than warm-up, then full
    for (int i = 0; i < 9; i++) kc[i] = $signed(8'($urandom));
    load_kernel();
    fill_random();
    run_frame(13, 100, 100);
    fill_random();
    run_frame(27, 70, 80);
    fill_random();
    run_frame(W*H, 70, 60);
    drain();

    // Random frames back to back, random weights
    for (int f = 0; f < 20; f++) begin
      for (int i = 0; i < 9; i++) kc[i] = $signed(8'($urandom));
      load_kernel();
      fill_random();
      run_frame(W*H, 40 + ($urandom % 61), 30 + ($urandom % 71));
      drain();
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nbad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
      $finish;
    end
  end

endmodule